// File: doc/BRIEF.md
# Software-Managed Translation Table with Associative Probe

This block holds the page translation table of a processor whose page-table walks are handled by software. Each slot describes a pair of adjacent pages (even and odd) and keeps four words: the page-size mask, the virtual-page/address-space word, and one frame descriptor for each page of the pair. Software loads the staging words on the block's inputs and issues one command per cycle. A command can write a slot by explicit index, write a slot chosen by a free-running random index, read a slot back into the read-back outputs, or probe the table for the slot that maps a virtual page.

When a slot is written, the block derives and keeps a shared global flag, two page-frame numbers trimmed by the page mask, a scratch-memory flag and the masked virtual-page tag. A probe compares the masked tag of every slot in parallel and reports the lowest matching slot, or a miss code. Read and probe results are registered and appear on the outputs one cycle after the command. They then hold until the next command of the same kind.

Top module: `soft_tlb`

## Requirements
- R1: After reset every slot holds all-zero words and flags, and every output is zero.
- R2: Command codes on `cmd` are 0 idle, 1 read, 2 write by index, 3 write by random index, 4 probe. Index-based commands use only bits 5:0 of `index_in`. A random write uses only bits 5:0 of `random_in`. All higher bits are ignored.
- R3: On a write the slot's global flag is set only when bit 0 of both frame words is 1. A read returns each frame word with its bit 0 replaced by that flag.
- R4: On a write each page-frame number is frame-word bits 25:6 with the bits cleared wherever page-mask bits 24:13 are set (mask bit 13 clears frame bit 0). A read shows these on `rd_pfn_even` and `rd_pfn_odd`.
- R5: On a write the scratch flag is taken from bit 31 of the even frame word. A read shows it on `rd_scratch`.
- R6: A read returns the page mask unchanged. It returns the virtual-page word with bits 12:8 cleared and with every bit that is set in the page mask cleared.
- R7: A probe matches a slot when the stored tag equals bits 31:13 of `entryhi_in` after both are masked by the slot's page-mask bits 24:13. The stored tag is bits 31:13 of the written virtual-page word. The slot must also be global, or its bits 7:0 must equal `entryhi_in` bits 7:0.
- R8: When several slots match, the probe reports the lowest slot number.
- R9: A probe hit puts the zero-extended slot number on `probe_index`. A miss puts 0x80000000 there.
- R10: Read and probe results appear in the cycle after the command. Read-back outputs change only on a read, and `probe_index` changes only on a probe.
- R11: A write whose selected slot number is at or above the table depth changes nothing. A read of such a slot number returns zero on every read-back output.
- R12: Command codes 5, 6 and 7 change neither the table nor any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd | input | 3 | Command code, sampled every cycle |
| index_in | input | 32 | Staged slot index for read, indexed write and (unused) probe |
| random_in | input | 32 | Staged random slot index for random writes |
| pagemask_in | input | 32 | Staged page-size mask |
| entryhi_in | input | 32 | Staged virtual page tag (31:13) and address-space id (7:0); also the probe key |
| entrylo0_in | input | 32 | Staged even-page frame word |
| entrylo1_in | input | 32 | Staged odd-page frame word |
| rd_pagemask | output | 32 | Read-back page mask |
| rd_entryhi | output | 32 | Read-back virtual-page word, masked |
| rd_entrylo0 | output | 32 | Read-back even frame word with global flag in bit 0 |
| rd_entrylo1 | output | 32 | Read-back odd frame word with global flag in bit 0 |
| rd_pfn_even | output | 20 | Read-back even page-frame number |
| rd_pfn_odd | output | 20 | Read-back odd page-frame number |
| rd_scratch | output | 1 | Read-back scratch flag |
| probe_index | output | 32 | Probe result: slot number or 0x80000000 |

## Verification
The bench builds the table with 12 slots instead of the default 48. With that depth every slot can be written, read and probed in a few hundred cycles. Slot numbers 12 to 63, which the 6-bit index field can still name, become reachable as out-of-range cases for both indexed and random writes and for reads. The small depth also makes it cheap to plant duplicate tags and global slots, so probe priority and address-space filtering can be checked against a full scan of the bench's own model after every change.

// File: rtl/soft_tlb_pkg.sv
`timescale 1ns/1ps
package soft_tlb_pkg;

    localparam int WORD_W   = 32;
    localparam int TAG_W    = 19;
    localparam int ASID_W   = 8;
    localparam int MASK_W   = 12;
    localparam int PFN_W    = 20;
    localparam int SEL_W    = 6;
    localparam logic [WORD_W-1:0] MISS_CODE = 32'h8000_0000;
    localparam logic [WORD_W-1:0] HI_RSVD   = 32'h0000_1F00;

    typedef enum logic [2:0] {
        OP_IDLE   = 3'd0,
        OP_READ   = 3'd1,
        OP_WR_IDX = 3'd2,
        OP_WR_RND = 3'd3,
        OP_PROBE  = 3'd4
    } tlb_op_e;

    // One table slot: raw staged words plus fields derived at write time
    typedef struct packed {
        logic [WORD_W-1:0] pm_raw;
        logic [WORD_W-1:0] hi_raw;
        logic [WORD_W-1:0] lo0_raw;
        logic [WORD_W-1:0] lo1_raw;
        logic [TAG_W-1:0]  tag;
        logic              glob;
        logic              scratch;
        logic [PFN_W-1:0]  pfn_even;
        logic [PFN_W-1:0]  pfn_odd;
    } tlb_slot_t;

    // Formatted read-back view of one slot
    typedef struct packed {
        logic [WORD_W-1:0] pm;
        logic [WORD_W-1:0] hi;
        logic [WORD_W-1:0] lo0;
        logic [WORD_W-1:0] lo1;
        logic [PFN_W-1:0]  pfn_even;
        logic [PFN_W-1:0]  pfn_odd;
        logic              scratch;
    } tlb_view_t;

    function automatic logic [MASK_W-1:0] mask_field(input logic [WORD_W-1:0] pm);
        return pm[24:13];
    endfunction

    function automatic logic [TAG_W-1:0] tag_mask(input logic [WORD_W-1:0] pm);
        return {{(TAG_W-MASK_W){1'b0}}, mask_field(pm)};
    endfunction

    function automatic logic [PFN_W-1:0] frame_of(input logic [WORD_W-1:0] lo,
                                                  input logic [WORD_W-1:0] pm);
        return lo[25:6] & ~{{(PFN_W-MASK_W){1'b0}}, mask_field(pm)};
    endfunction

    function automatic tlb_slot_t build_slot(input logic [WORD_W-1:0] pm,
                                             input logic [WORD_W-1:0] hi,
                                             input logic [WORD_W-1:0] lo0,
                                             input logic [WORD_W-1:0] lo1);
        tlb_slot_t s;
        s.pm_raw   = pm;
        s.hi_raw   = hi;
        s.lo0_raw  = lo0;
        s.lo1_raw  = lo1;
        s.tag      = hi[31:13] & ~tag_mask(pm);
        s.glob     = lo0[0] & lo1[0];
        s.scratch  = lo0[31];
        s.pfn_even = frame_of(lo0, pm);
        s.pfn_odd  = frame_of(lo1, pm);
        return s;
    endfunction

endpackage

// File: rtl/tlb_slot_array.sv
`timescale 1ns/1ps
module tlb_slot_array
    import soft_tlb_pkg::*;
#(
    parameter int DEPTH = 48,
    parameter int IW    = 6
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [IW-1:0] wr_slot,
    input  tlb_slot_t     wr_data,
    output tlb_slot_t     slots_q [DEPTH]
);

    tlb_slot_t slots_d [DEPTH];

    always_comb begin
        for (int i = 0; i < DEPTH; i++) begin
            slots_d[i] = slots_q[i];
            if (wr_en && (wr_slot == IW'(i))) begin
                slots_d[i] = wr_data;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) begin
                slots_q[i] <= '0;
            end
        end else begin
            for (int i = 0; i < DEPTH; i++) begin
                slots_q[i] <= slots_d[i];
            end
        end
    end

endmodule

// File: rtl/tlb_probe_match.sv
`timescale 1ns/1ps
module tlb_probe_match
    import soft_tlb_pkg::*;
#(
    parameter int DEPTH = 48,
    parameter int IW    = 6
) (
    input  tlb_slot_t         slots [DEPTH],
    input  logic [WORD_W-1:0] key_hi,
    output logic              hit,
    output logic [IW-1:0]     hit_slot
);

    logic [DEPTH-1:0] hit_vec;

    // One comparator per slot, all evaluated in parallel
    for (genvar g = 0; g < DEPTH; g++) begin : g_cmp
        logic [TAG_W-1:0] key_tag;
        logic             tag_eq;
        logic             asid_eq;
        assign key_tag    = key_hi[31:13] & ~tag_mask(slots[g].pm_raw);
        assign tag_eq     = (key_tag == slots[g].tag);
        assign asid_eq    = (slots[g].hi_raw[ASID_W-1:0] == key_hi[ASID_W-1:0]);
        assign hit_vec[g] = tag_eq && (slots[g].glob || asid_eq);
    end

    // Priority encoder: the lowest numbered match wins
    always_comb begin
        hit_slot = '0;
        for (int i = DEPTH - 1; i >= 0; i--) begin
            if (hit_vec[i]) begin
                hit_slot = IW'(i);
            end
        end
    end

    assign hit = |hit_vec;

endmodule

// File: rtl/tlb_read_view.sv
`timescale 1ns/1ps
module tlb_read_view
    import soft_tlb_pkg::*;
#(
    parameter int DEPTH = 48,
    parameter int IW    = 6
) (
    input  tlb_slot_t     slots [DEPTH],
    input  logic [IW-1:0] rd_slot,
    input  logic          rd_ok,
    output tlb_view_t     view
);

    tlb_slot_t pick;

    always_comb begin
        pick = '0;
        for (int i = 0; i < DEPTH; i++) begin
            if (rd_ok && (rd_slot == IW'(i))) begin
                pick = slots[i];
            end
        end
    end

    always_comb begin
        view.pm       = pick.pm_raw;
        view.hi       = pick.hi_raw & ~(pick.pm_raw | HI_RSVD);
        view.lo0      = {pick.lo0_raw[WORD_W-1:1], pick.glob};
        view.lo1      = {pick.lo1_raw[WORD_W-1:1], pick.glob};
        view.pfn_even = pick.pfn_even;
        view.pfn_odd  = pick.pfn_odd;
        view.scratch  = pick.scratch;
    end

endmodule

// File: rtl/soft_tlb.sv
`timescale 1ns/1ps
module soft_tlb
    import soft_tlb_pkg::*;
#(
    parameter int NUM_ENTRIES = 48
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic [2:0]  cmd,
    input  logic [31:0] index_in,
    input  logic [31:0] random_in,
    input  logic [31:0] pagemask_in,
    input  logic [31:0] entryhi_in,
    input  logic [31:0] entrylo0_in,
    input  logic [31:0] entrylo1_in,
    output logic [31:0] rd_pagemask,
    output logic [31:0] rd_entryhi,
    output logic [31:0] rd_entrylo0,
    output logic [31:0] rd_entrylo1,
    output logic [19:0] rd_pfn_even,
    output logic [19:0] rd_pfn_odd,
    output logic        rd_scratch,
    output logic [31:0] probe_index
);

    localparam int IW = (NUM_ENTRIES > 1) ? $clog2(NUM_ENTRIES) : 1;

    typedef struct packed {
        tlb_view_t         rd;
        logic [WORD_W-1:0] prb;
    } out_t;

    out_t              out_d, out_q;
    tlb_slot_t         slots [NUM_ENTRIES];
    tlb_view_t         view;
    logic              wr_en;
    logic [SEL_W-1:0]  wr_sel, rd_sel;
    logic              wr_ok, rd_ok;
    logic              hit;
    logic [IW-1:0]     hit_slot;

    assign rd_sel = index_in[SEL_W-1:0];
    assign wr_sel = (cmd == OP_WR_RND) ? random_in[SEL_W-1:0] : index_in[SEL_W-1:0];
    assign wr_ok  = (int'(wr_sel) < NUM_ENTRIES);
    assign rd_ok  = (int'(rd_sel) < NUM_ENTRIES);
    assign wr_en  = ((cmd == OP_WR_IDX) || (cmd == OP_WR_RND)) && wr_ok;

    tlb_slot_array #(.DEPTH(NUM_ENTRIES), .IW(IW)) u_array (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_slot (wr_sel[IW-1:0]),
        .wr_data (build_slot(pagemask_in, entryhi_in, entrylo0_in, entrylo1_in)),
        .slots_q (slots)
    );

    tlb_probe_match #(.DEPTH(NUM_ENTRIES), .IW(IW)) u_match (
        .slots    (slots),
        .key_hi   (entryhi_in),
        .hit      (hit),
        .hit_slot (hit_slot)
    );

    tlb_read_view #(.DEPTH(NUM_ENTRIES), .IW(IW)) u_view (
        .slots   (slots),
        .rd_slot (rd_sel[IW-1:0]),
        .rd_ok   (rd_ok),
        .view    (view)
    );

    always_comb begin
        out_d = out_q;
        case (cmd)
            OP_READ:  out_d.rd  = view;
            OP_PROBE: out_d.prb = hit ? WORD_W'(hit_slot) : MISS_CODE;
            default:  out_d     = out_q;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_q <= '0;
        end else begin
            out_q <= out_d;
        end
    end

    assign rd_pagemask = out_q.rd.pm;
    assign rd_entryhi  = out_q.rd.hi;
    assign rd_entrylo0 = out_q.rd.lo0;
    assign rd_entrylo1 = out_q.rd.lo1;
    assign rd_pfn_even = out_q.rd.pfn_even;
    assign rd_pfn_odd  = out_q.rd.pfn_odd;
    assign rd_scratch  = out_q.rd.scratch;
    assign probe_index = out_q.prb;

endmodule

// File: rtl/soft_tlb_chk.sv
`timescale 1ns/1ps
module soft_tlb_chk #(
    parameter int NUM_ENTRIES = 48
) (
    input logic        clk,
    input logic        rst_n,
    input logic [2:0]  cmd,
    input logic [31:0] index_in,
    input logic [31:0] rd_pagemask,
    input logic [31:0] rd_entryhi,
    input logic [31:0] rd_entrylo0,
    input logic [31:0] rd_entrylo1,
    input logic [19:0] rd_pfn_even,
    input logic [19:0] rd_pfn_odd,
    input logic        rd_scratch,
    input logic [31:0] probe_index
);

    // R9
    probe_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (probe_index == 32'h8000_0000) || (probe_index < NUM_ENTRIES));

    // R10
    rd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd != 3'd1) |=> ($stable(rd_pagemask) && $stable(rd_entryhi) &&
                           $stable(rd_entrylo0) && $stable(rd_entrylo1) &&
                           $stable(rd_pfn_even) && $stable(rd_pfn_odd) &&
                           $stable(rd_scratch)));

    // R10
    probe_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd != 3'd4) |=> $stable(probe_index));

    // R11
    oob_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd == 3'd1 && index_in[5:0] >= NUM_ENTRIES) |=>
        (rd_pagemask == 0 && rd_entryhi == 0 && rd_entrylo0 == 0 &&
         rd_entrylo1 == 0 && rd_pfn_even == 0 && rd_pfn_odd == 0 && !rd_scratch));

    // R6
    hi_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((rd_entryhi & rd_pagemask) == 0) && (rd_entryhi[12:8] == 5'd0));

    // R3
    glob_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_entrylo0[0] == rd_entrylo1[0]);

endmodule

bind soft_tlb soft_tlb_chk #(.NUM_ENTRIES(NUM_ENTRIES)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .cmd         (cmd),
    .index_in    (index_in),
    .rd_pagemask (rd_pagemask),
    .rd_entryhi  (rd_entryhi),
    .rd_entrylo0 (rd_entrylo0),
    .rd_entrylo1 (rd_entrylo1),
    .rd_pfn_even (rd_pfn_even),
    .rd_pfn_odd  (rd_pfn_odd),
    .rd_scratch  (rd_scratch),
    .probe_index (probe_index)
);

// File: tb/test_soft_tlb.sv
`timescale 1ns/1ps
module test_soft_tlb;

    localparam int N = 12;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  cmd = 3'd0;
    logic [31:0] index_in = '0, random_in = '0, pagemask_in = '0;
    logic [31:0] entryhi_in = '0, entrylo0_in = '0, entrylo1_in = '0;
    logic [31:0] rd_pagemask, rd_entryhi, rd_entrylo0, rd_entrylo1, probe_index;
    logic [19:0] rd_pfn_even, rd_pfn_odd;
    logic        rd_scratch;

    int tests = 0;
    int fails = 0;

    // bench model of the table
    logic [31:0] m_pm [N];
    logic [31:0] m_hi [N];
    logic [31:0] m_lo0[N];
    logic [31:0] m_lo1[N];

    always #2.5 clk = ~clk;

    soft_tlb #(.NUM_ENTRIES(N)) i_soft_tlb (
        .clk(clk), .rst_n(rst_n), .cmd(cmd),
        .index_in(index_in), .random_in(random_in), .pagemask_in(pagemask_in),
        .entryhi_in(entryhi_in), .entrylo0_in(entrylo0_in), .entrylo1_in(entrylo1_in),
        .rd_pagemask(rd_pagemask), .rd_entryhi(rd_entryhi),
        .rd_entrylo0(rd_entrylo0), .rd_entrylo1(rd_entrylo1),
        .rd_pfn_even(rd_pfn_even), .rd_pfn_odd(rd_pfn_odd),
        .rd_scratch(rd_scratch), .probe_index(probe_index)
    );

    function automatic logic [31:0] mix(input int a);
        logic [31:0] v;
        v = 32'(a) * 32'h9E37_79B1;
        v = v ^ (v >> 15) ^ 32'h5BD1_E995;
        v = v * 32'h0000_0B6B;
        return v ^ (v >> 13);
    endfunction

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic issue(input logic [2:0] c, input logic [31:0] idx, input logic [31:0] rnd,
                         input logic [31:0] pm, input logic [31:0] hi,
                         input logic [31:0] lo0, input logic [31:0] lo1);
        @(negedge clk);
        cmd = c; index_in = idx; random_in = rnd; pagemask_in = pm;
        entryhi_in = hi; entrylo0_in = lo0; entrylo1_in = lo1;
        @(negedge clk);
        cmd = 3'd0;
    endtask

    task automatic write_slot(input bit rnd_mode, input logic [31:0] sel,
                              input logic [31:0] pm, input logic [31:0] hi,
                              input logic [31:0] lo0, input logic [31:0] lo1);
        int s;
        s = int'(sel[5:0]);
        if (rnd_mode) issue(3'd3, 32'hFFFF_FFFF, sel, pm, hi, lo0, lo1);
        else          issue(3'd2, sel, 32'hFFFF_FFFF, pm, hi, lo0, lo1);
        if (s < N) begin
            m_pm[s] = pm; m_hi[s] = hi; m_lo0[s] = lo0; m_lo1[s] = lo1;
        end
    endtask

    // R3 R4 R5 R6 R11: expected read-back from the model
    task automatic read_check(input string req, input logic [31:0] idx);
        int s;
        logic [31:0] pm, hi, lo0, lo1;
        logic g;
        logic [19:0] fm;
        s = int'(idx[5:0]);
        issue(3'd1, idx, 32'h0, 32'h0, 32'h0, 32'h0, 32'h0);
        if (s < N) begin
            pm = m_pm[s]; hi = m_hi[s]; lo0 = m_lo0[s]; lo1 = m_lo1[s];
        end else begin
            pm = 0; hi = 0; lo0 = 0; lo1 = 0;
        end
        g  = lo0[0] & lo1[0];
        fm = {8'h00, pm[24:13]};
        check({req, " pagemask"}, 64'(rd_pagemask), 64'(pm));
        check({req, " entryhi"},  64'(rd_entryhi),  64'(hi & ~(pm | 32'h1F00)));
        check({req, " lo0"},      64'(rd_entrylo0), 64'({lo0[31:1], g}));
        check({req, " lo1"},      64'(rd_entrylo1), 64'({lo1[31:1], g}));
        check({req, " pfn"},      {rd_pfn_even, rd_pfn_odd, rd_scratch},
              {lo0[25:6] & ~fm, lo1[25:6] & ~fm, lo0[31]});
    endtask

    // R7 R8 R9: expected probe result from a full scan of the model
    task automatic probe_check(input string req, input logic [31:0] key);
        logic [31:0] exp;
        logic [18:0] m;
        exp = 32'h8000_0000;
        for (int i = N - 1; i >= 0; i--) begin
            m = {7'h00, m_pm[i][24:13]};
            if (((m_hi[i][31:13] & ~m) == (key[31:13] & ~m)) &&
                ((m_lo0[i][0] & m_lo1[i][0]) || (m_hi[i][7:0] == key[7:0])))
                exp = 32'(i);
        end
        issue(3'd4, 32'hFFFF_FFFF, 32'h0, 32'h0, key, 32'h0, 32'h0);
        check(req, 64'(probe_index), 64'(exp));
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        tests++; fails++;
        $display("FAIL watchdog actual=running expected=done");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin : main
        logic [31:0] hold_hi, hold_prb;
        for (int i = 0; i < N; i++) begin
            m_pm[i] = 0; m_hi[i] = 0; m_lo0[i] = 0; m_lo1[i] = 0;
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: outputs zero after reset
        check("R1 outputs", {rd_pagemask, rd_entryhi, 64'(probe_index)},
              {64'h0, 64'h0} [63:0]);
        check("R1 lo", {rd_entrylo0, rd_entrylo1}, 64'h0);
        // R1 R11: every slot number reads back zero
        for (int i = 0; i < 64; i++) read_check("R1 R11 reset read", 32'(i));

        // R2: indexed writes with garbage upper index bits, random writes on odd slots
        for (int i = 0; i < N; i++) begin
            logic [31:0] pm, hi, lo0, lo1;
            pm  = mix(i)      & 32'h01FF_E000;
            hi  = mix(i + 100);
            lo0 = mix(i + 200);
            lo1 = mix(i + 300);
            if (i % 3 == 0) begin lo0[0] = 1'b1; lo1[0] = 1'b1; end
            if (i % 2 == 1) write_slot(1'b1, (mix(i + 400) << 6) | 32'(i), pm, hi, lo0, lo1);
            else            write_slot(1'b0, (mix(i + 500) << 6) | 32'(i), pm, hi, lo0, lo1);
        end
        for (int i = 0; i < N; i++) read_check("R2 R3 R4 R5 R6 sweep", 32'hABCD_0000 | 32'(i << 6) | 32'(i));

        // R3: only one frame word global gives no global flag
        write_slot(1'b0, 32'd2, 32'h0000_6000, 32'h1234_5F7A, 32'h8000_0041, 32'h0000_0000);
        read_check("R3 R5 single glob", 32'd2);
        write_slot(1'b0, 32'd3, 32'h01FF_E000, 32'hFFFF_FFFF, 32'h03FF_FFFF, 32'h03FF_FFFF);
        read_check("R3 R4 R6 full mask", 32'd3);

        // R7: probe each slot with its own key, with a foreign ASID, and with masked bits flipped
        for (int i = 0; i < N; i++) begin
            probe_check("R7 own key", m_hi[i]);
            probe_check("R7 asid mismatch", m_hi[i] ^ 32'h0000_005A);
            probe_check("R7 masked bits", m_hi[i] ^ (m_pm[i] & 32'h01FF_E000));
        end

        // R8: duplicates, lowest slot wins
        write_slot(1'b0, 32'd4, 32'h0, 32'h7700_0011, 32'h0, 32'h0);
        write_slot(1'b1, 32'd9, 32'h0, 32'h7700_0011, 32'h0, 32'h0);
        probe_check("R8 duplicate", 32'h7700_0011);
        check("R8 lowest", 64'(probe_index), 64'd4);
        // R7: global slot matches any ASID
        write_slot(1'b0, 32'd7, 32'h0, 32'h5500_2022, 32'h1, 32'h1);
        probe_check("R7 global", 32'h5500_20EE);
        check("R7 global idx", 64'(probe_index), 64'd7);
        // R9: miss code
        probe_check("R9 miss", 32'h0000_2077);
        check("R9 miss code", 64'(probe_index), 64'h8000_0000);

        // R11: out-of-range writes change nothing
        write_slot(1'b0, 32'd40, 32'h0, 32'h7700_0011, 32'hFFFF_FFFF, 32'hFFFF_FFFF);
        write_slot(1'b1, 32'd63, 32'h0, 32'h7700_0011, 32'hFFFF_FFFF, 32'hFFFF_FFFF);
        for (int i = 0; i < N; i++) read_check("R11 oob write", 32'(i));
        read_check("R11 oob read", 32'd12);

        // R10 R12: outputs hold across non-matching commands
        read_check("R10 setup", 32'd5);
        probe_check("R10 setup probe", m_hi[5]);
        hold_hi = rd_entryhi; hold_prb = probe_index;
        issue(3'd5, 32'd5, 32'd5, 32'hFFFF_FFFF, 32'h0, 32'h1, 32'h1);
        issue(3'd6, 32'd5, 32'd5, 32'hFFFF_FFFF, 32'h0, 32'h1, 32'h1);
        issue(3'd7, 32'd5, 32'd5, 32'hFFFF_FFFF, 32'h0, 32'h1, 32'h1);
        check("R12 rd hold", 64'(rd_entryhi), 64'(hold_hi));
        check("R12 probe hold", 64'(probe_index), 64'(hold_prb));
        write_slot(1'b0, 32'd6, 32'h0, 32'h1111_0000, 32'h0, 32'h0);
        check("R10 rd hold on write", 64'(rd_entryhi), 64'(hold_hi));
        read_check("R10 read", 32'd0);
        check("R10 probe hold on read", 64'(probe_index), 64'(hold_prb));
        for (int i = 0; i < N; i++) read_check("R12 table intact", 32'(i));

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule